// File: doc/BRIEF.md
# Synchronous SRAM Boundary-Scan Test Port

This block is the test access port of a synchronous SRAM. It follows the IEEE 1149.1 state machine but has a reduced instruction set. A tester drives a test clock, a mode select and serial data into the block and reads serial data back out. Under control of a 3-bit instruction, the block places one of three data registers between the serial input and the serial output: a 1-bit bypass stage, a 32-bit identification word, or a boundary chain. The boundary chain captures the SRAM's pin vector from a parallel port.

Two instructions tell the SRAM output drivers to float through an output-disable flag. A third instruction captures the pins without disturbing normal operation. None of the boundary instructions ever drives shifted-in data back onto the pins. The width variant is set by a parameter. The wide (x36) variant has a 70-cell chain and the narrow (x18) variant has a 51-cell chain, and the identification word changes with the variant.

Top module: `sram_tap`

## Requirements
- R1: While `trst_n` is low the controller is held in Test-Logic-Reset, the active instruction is IDCODE (001), `tdo_en` is 0 and `out_disable` is 0. After release, a data-register scan returns the identification word.
- R2: Five consecutive rising TCK edges with `tms` high bring the controller to Test-Logic-Reset from any state. The instruction then returns to IDCODE at the next falling edge.
- R3: In Capture-IR the instruction shift stage loads 001. Data shifts least significant bit first on rising TCK edges, so an IR scan emits 1, 0, 0.
- R4: With IDCODE active, the scanned word (LSB first) is {revision 4'b0100, internal id 4'b1010, type 6'b000000, width/density (6'b100101 wide, 6'b010101 narrow), vendor 12'b000001101001}, with bits 31 down to 0 in that order.
- R5: BYPASS (111) selects a 1-bit register that captures 0. The serial output is therefore 0 followed by the serial input delayed by one clock. `out_disable` stays 0.
- R6: The reserved codes 011, 101 and 110 behave as BYPASS and leave `out_disable` at 0.
- R7: EXTEST (000) and SAMPLE Z (010) capture `pins_in` into the boundary chain, select it, and hold `out_disable` at 1 while active.
- R8: SAMPLE/PRELOAD (100) captures `pins_in` and selects the boundary chain with `out_disable` at 0. Shifted-in data is never presented anywhere: the next capture again reflects `pins_in`.
- R9: `tdo` and `tdo_en` change only on falling TCK edges. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR.
- R10: The active instruction, and hence `out_disable`, changes only on the falling edge inside Update-IR or Test-Logic-Reset. Shifting new bits in IR or DR scans has no effect on it.
- R11: The boundary chain has 70 cells (wide) or 51 cells (narrow). Cell k captures `pins_in[k]`. Cell 0 feeds `tdo` and the last cell loads from `tdi`, so after the chain length the serial input reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| pins_in | input | BSR_LEN | SRAM pin vector captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Serial output enable (high only in shift states) |
| out_disable | output | 1 | Forces SRAM output drivers to high impedance |

## Verification
The hardest situation to reach from the ports is the TMS-only return to reset (R2) from a deep data-register state while an output-disabling instruction is active. The stimulus loads EXTEST, enters Shift-DR for one bit, parks in Pause-DR, and then holds `tms` high for five edges. It then checks that the flag drops only after the falling edge in Test-Logic-Reset. The instruction switch is checked in a similar way, by sampling `out_disable` between the rising and falling edges of Update-IR. Overlong boundary scans show the `tdi` bits re-emerging after exactly the chain length.

// File: rtl/sram_tap_pkg.sv
`timescale 1ns/1ps
package sram_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    OP_EXTEST  = 3'b000,
    OP_IDCODE  = 3'b001,
    OP_SAMPLEZ = 3'b010,
    OP_RSV3    = 3'b011,
    OP_SAMPLE  = 3'b100,
    OP_RSV5    = 3'b101,
    OP_RSV6    = 3'b110,
    OP_BYPASS  = 3'b111
  } tap_op_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  localparam int IR_LEN = 3;
  localparam int ID_LEN = 32;
  localparam logic [IR_LEN-1:0] IR_CAPTURE = 3'b001;

  function automatic int bsr_len(input bit wide);
    return wide ? 70 : 51;
  endfunction

  function automatic logic [ID_LEN-1:0] id_word(input bit wide);
    logic [5:0] dens;
    dens = wide ? 6'b100101 : 6'b010101;
    return {4'b0100, 4'b1010, 6'b000000, dens, 12'b0000_0110_1001};
  endfunction

  function automatic dr_path_e op_path(input tap_op_e op);
    case (op)
      OP_IDCODE:                       return PATH_ID;
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return PATH_BSR;
      default:                         return PATH_BYP;
    endcase
  endfunction

  function automatic logic op_hiz(input tap_op_e op);
    return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
      default:   return ST_RESET;
    endcase
  endfunction

endpackage

// File: rtl/sram_tap_fsm.sv
`timescale 1ns/1ps
module sram_tap_fsm
  import sram_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/sram_tap_ir.sv
`timescale 1ns/1ps
module sram_tap_ir
  import sram_tap_pkg::*;
(
  input  logic              tck,
  input  logic              trst_n,
  input  tap_state_e        state,
  input  logic              tdi,
  output logic [IR_LEN-1:0] ir_sr,
  output tap_op_e           ir_act
);

  // shift stage on the rising edge
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sr <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
  end

  // active instruction moves on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_act <= OP_IDCODE;
    else if (state == ST_RESET)  ir_act <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_act <= tap_op_e'(ir_sr);
  end

endmodule

// File: rtl/sram_tap_dr.sv
`timescale 1ns/1ps
module sram_tap_dr
  import sram_tap_pkg::*;
#(
  parameter bit WIDE    = 1'b1,
  parameter int BSR_LEN = bsr_len(WIDE)
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  logic               tdi,
  input  dr_path_e           path,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               byp_q,
  output logic               dr_lsb
);

  localparam logic [ID_LEN-1:0] ID_CONST = id_word(WIDE);

  logic               cap_dr, sh_dr;
  logic               sel_byp, sel_id, sel_bsr;
  logic [ID_LEN-1:0]  id_q;
  logic [BSR_LEN-1:0] bsr_q;

  assign cap_dr  = (state == ST_CAP_DR);
  assign sh_dr   = (state == ST_SH_DR);
  assign sel_byp = (path == PATH_BYP);
  assign sel_id  = (path == PATH_ID);
  assign sel_bsr = (path == PATH_BSR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              byp_q <= 1'b0;
    else if (sel_byp && cap_dr) byp_q <= 1'b0;
    else if (sel_byp && sh_dr)  byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               id_q <= ID_CONST;
    else if (sel_id && cap_dr) id_q <= ID_CONST;
    else if (sel_id && sh_dr)  id_q <= {tdi, id_q[ID_LEN-1:1]};
  end

  // boundary cells, highest cell loads from tdi
  for (genvar k = 0; k < BSR_LEN; k++) begin : g_cell
    logic shin;
    if (k == BSR_LEN-1) begin : g_top
      assign shin = tdi;
    end else begin : g_mid
      assign shin = bsr_q[k+1];
    end
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                bsr_q[k] <= 1'b0;
      else if (sel_bsr && cap_dr) bsr_q[k] <= pins_in[k];
      else if (sel_bsr && sh_dr)  bsr_q[k] <= shin;
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_q[0];
      PATH_BSR: dr_lsb = bsr_q[0];
      default:  dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/sram_tap.sv
`timescale 1ns/1ps
module sram_tap
  import sram_tap_pkg::*;
#(
  parameter bit    WIDE    = 1'b1,
  localparam int   BSR_LEN = bsr_len(WIDE)
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic               out_disable
);

  tap_state_e        st_q;
  tap_op_e           ir_act;
  logic [IR_LEN-1:0] ir_sr;
  dr_path_e          dr_sel;
  logic              byp_q, dr_lsb;
  logic              in_sh_dr, in_sh_ir;

  sram_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(st_q)
  );

  sram_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(st_q), .tdi(tdi),
    .ir_sr(ir_sr), .ir_act(ir_act)
  );

  assign dr_sel      = op_path(ir_act);
  assign out_disable = op_hiz(ir_act);

  sram_tap_dr #(.WIDE(WIDE), .BSR_LEN(BSR_LEN)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(st_q), .tdi(tdi), .path(dr_sel),
    .pins_in(pins_in), .byp_q(byp_q), .dr_lsb(dr_lsb)
  );

  assign in_sh_dr = (st_q == ST_SH_DR);
  assign in_sh_ir = (st_q == ST_SH_IR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_sh_dr | in_sh_ir;
      tdo    <= in_sh_ir ? ir_sr[0] : dr_lsb;
    end
  end

endmodule

// File: rtl/sram_tap_chk.sv
`timescale 1ns/1ps
module sram_tap_chk
  import sram_tap_pkg::*;
(
  input logic              tck,
  input logic              trst_n,
  input logic              tms,
  input tap_state_e        state,
  input tap_op_e           ir_act,
  input logic [IR_LEN-1:0] ir_sr,
  input dr_path_e          dr_sel,
  input logic              byp_q,
  input logic              tdo_en,
  input logic              out_disable
);

  logic [2:0] ones;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  ones <= 3'd0;
    else if (tms) ones <= (ones == 3'd5) ? 3'd5 : ones + 3'd1;
    else          ones <= 3'd0;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (state == ST_RESET)); // R2

  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE)); // R3

  AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && dr_sel == PATH_BYP) |=> !byp_q); // R5

  AST_TDO_WINDOW: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (state == ST_SH_DR || state == ST_SH_IR)); // R9

  AST_INSN_CHANGE: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ir_act) |-> (state == ST_UPD_IR || state == ST_RESET)); // R10

  AST_HIZ_CHANGE: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(out_disable) |-> (state == ST_UPD_IR || state == ST_RESET)); // R7

  AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && $past(state) == ST_RESET) |-> (ir_act == OP_IDCODE)); // R1

endmodule

bind sram_tap sram_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(st_q), .ir_act(ir_act),
  .ir_sr(ir_sr), .dr_sel(dr_sel), .byp_q(byp_q), .tdo_en(tdo_en),
  .out_disable(out_disable)
);

// File: tb/sim_sram_tap.sv
`timescale 1ns/1ps
module sim_sram_tap;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic [69:0] pins = '0;
  logic        tdo, tdo_en, out_disable;

  sram_tap #(.WIDE(1'b1)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pins_in(pins),
    .tdo(tdo), .tdo_en(tdo_en), .out_disable(out_disable)
  );

  always #2 tck = ~tck;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic exp_q[$];
  int   tag_q[$];
  logic e_bit;
  int   e_tag;

  localparam logic [31:0] ID_EXP = {4'b0100, 4'b1010, 6'b000000, 6'b100101, 12'b000001101001};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic b, input int tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: one expected bit per enabled shift cycle
  always @(negedge tck) begin
    #0.5;
    if (trst_n && tdo_en === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected shift output actual=%b expected=none", tdo);
      end else begin
        e_bit = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        if (tdo !== e_bit) begin
          fails++;
          $display("FAIL R%0d tdo actual=%b expected=%b", e_tag, tdo, e_bit);
        end
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #0.5;
    tms = m;
    tdi = d;
  endtask

  task automatic goto_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic scan_ir(input logic [2:0] op, input int tag, output logic od_mid);
    push(1'b1, tag); push(1'b0, tag); push(1'b0, tag);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(i == 2, op[i]);
    step(1'b1, 1'b0);
    @(posedge tck); #0.5;
    od_mid = out_disable;
    step(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din, input logic [127:0] expv, input int tag);
    for (int i = 0; i < n; i++) push(expv[i], tag);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) step(i == n-1, din[i]);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic        od;
    logic [127:0] d, x;
    logic [69:0] pa, pb, pc, pe;

    // R1: reset state
    repeat (3) @(negedge tck);
    #0.5;
    chk("R1 tdo_en", tdo_en, 0);
    chk("R1 out_disable", out_disable, 0);
    trst_n = 1'b1;
    goto_idle();
    scan_dr(32, 128'h0, 128'(ID_EXP), 1);           // R1 and R4: idcode after reset

    // R3 / R5: bypass with capture pattern
    scan_ir(3'b111, 3, od);
    chk("R10 no early change", od, 0);
    chk("R5 no disable", out_disable, 0);
    d = 128'h1B5;
    scan_dr(9, d, 128'({d[7:0], 1'b0}), 5);

    // R6: reserved codes
    scan_ir(3'b011, 6, od);
    chk("R6 code 011", out_disable, 0);
    scan_dr(3, 128'h5, 128'h2, 6);
    scan_ir(3'b101, 6, od);
    chk("R6 code 101", out_disable, 0);
    scan_dr(3, 128'h5, 128'h2, 6);
    scan_ir(3'b110, 6, od);
    chk("R6 code 110", out_disable, 0);
    scan_dr(3, 128'h5, 128'h2, 6);

    // R7 / R11: EXTEST with overlong scan
    pa = {6'h2A, 64'h5555_0F0F_3C3C_9696};
    pins = pa;
    scan_ir(3'b000, 7, od);
    chk("R10 before update", od, 0);
    chk("R7 extest disable", out_disable, 1);
    d = 128'h2;
    x = 128'({d[1:0], pa});
    scan_dr(72, d, x, 11);
    chk("R10 dr scan keeps insn", out_disable, 1);

    // R2: five tms-high edges from Pause-DR
    push(pa[0], 2);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    chk("R2 still disabled before fall", out_disable, 1);
    step(1'b1, 1'b0);
    chk("R2 disable dropped", out_disable, 0);
    chk("R2 tdo_en", tdo_en, 0);
    step(1'b0, 1'b0);
    scan_dr(32, 128'h0, 128'(ID_EXP), 2);

    // R7: SAMPLE Z
    pb = {6'h15, 64'hDEAD_BEEF_0123_4567};
    pins = pb;
    scan_ir(3'b010, 7, od);
    chk("R7 samplez disable", out_disable, 1);
    scan_dr(70, 128'h0, 128'(pb), 7);

    // R8: SAMPLE/PRELOAD
    pc = {6'h33, 64'hA5A5_5A5A_F00F_1234};
    pins = pc;
    scan_ir(3'b100, 8, od);
    chk("R10 old insn held in update", od, 1);
    chk("R8 no disable", out_disable, 0);
    scan_dr(70, 128'h3F_FFFF_FFFF_FFFF_FFFF, 128'(pc), 8);
    pe = {6'h0C, 64'h0F1E_2D3C_4B5A_6978};
    pins = pe;
    scan_dr(70, 128'h0, 128'(pe), 8);
    chk("R8 still enabled", out_disable, 0);

    // R9: tdo moves on the falling edge only
    scan_ir(3'b111, 9, od);
    push(1'b0, 9); push(1'b1, 9); push(1'b1, 9);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    @(posedge tck); #0.5;
    chk("R9 held after rise", tdo, 0);
    step(1'b0, 1'b1);
    chk("R9 moved after fall", tdo, 1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R9 enable off outside shift", tdo_en, 0);

    repeat (3) @(negedge tck);
    chk("R9 scoreboard drained", 128'(exp_q.size()), 0);
    finish_run();
  end

endmodule